// File: doc/BRIEF.md
# Multi-Core Wait-for-Event / Send-Event Controller

This block coordinates the low-power wait handshake between a set of processor cores. Each core owns a one-bit event mailbox and a sleep state. When a core executes a wait-for-event (WFE) instruction, the block checks that core's mailbox and its pending unmasked interrupts, and then does one of three things: it consumes a stored event, it lets the core run on, or it puts the core to sleep. When a core executes a send-event (SEV) instruction, the block sets the sender's own mailbox. It also raises an event-interrupt request on every other core that currently holds no stored event.

The event-interrupt line tells a core's interrupt logic that a remote event is waiting. No mask bit gates this line; only reset ranks above it. When the core takes the interrupt, it returns an acknowledge. The acknowledge stores the event in the core's mailbox and clears the request, and execution continues with no redirect. Any exception entry on a core also stores an event in that core's mailbox. A WFE whose condition check fails does not sleep; instead it re-arms the mailbox. A pending event request or a pending interrupt wakes a sleeping core.

Top module: `wfe_sev_ctrl`

## Requirements
- R1: A WFE with its condition passed, on a core whose mailbox holds 1, clears that mailbox. The core's `sleeping` output stays low.
- R2: A WFE with its condition passed, on a core whose mailbox holds 0 and whose `irq_pending` is high, keeps the core awake and leaves the mailbox at 0.
- R3: A WFE with its condition passed, on a core whose mailbox holds 0, with no interrupt pending and no wake cause present, raises that core's `sleeping` output from the next clock edge on.
- R4: A WFE whose `wfe_cond_ok` bit is low sets the core's mailbox to 1 and keeps the core awake.
- R5: An SEV pulse sets the issuing core's own mailbox to 1.
- R6: An SEV pulse raises `evt_irq` at the next edge on every other core whose mailbox is 0. A core whose mailbox is already 1 gets no request.
- R7: An `evt_ack` pulse clears that core's `evt_irq` at the next edge (unless a new request is posted in the same cycle) and sets its mailbox to 1.
- R8: An `exc_entry` pulse sets that core's mailbox to 1.
- R9: A sleeping core with a pending event request, a request being posted, or `irq_pending` high shows `wake` high in that same cycle. Its `sleeping` output goes low at the next edge.
- R10: After synchronous reset, every mailbox is 0, every core is awake, and no `evt_irq` or `wake` is raised.
- R11: SEV pulses from several cores in one cycle produce the union of their effects. Each issuer also receives the posts made by the other issuers.
- R12: If a core enters sleep in the same cycle that a wake cause reaches it, the wake wins and the core stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfe_pulse | input | N_CORES | One-cycle WFE execution strobe per core |
| wfe_cond_ok | input | N_CORES | Condition-check result for the WFE in the same cycle (1 = passed) |
| sev_pulse | input | N_CORES | One-cycle SEV execution strobe per core |
| irq_pending | input | N_CORES | Core has an unmasked interrupt pending |
| exc_entry | input | N_CORES | One-cycle exception-entry strobe per core |
| evt_ack | input | N_CORES | Core has taken its event interrupt |
| sleeping | output | N_CORES | Core is in the WFE sleep state |
| wake | output | N_CORES | Wake strobe for a sleeping core, combinational from the cause |
| evt_irq | output | N_CORES | Pending event-interrupt request |

## Verification
Two events can reach the same core in one cycle: that core's own WFE sleep entry, and a post caused by another core's SEV. The bench makes them collide by driving a passed WFE on one core and an SEV on another core in the same cycle, with the target core's mailbox cleared beforehand. The collision passes if the target core is awake after the edge and its event request is raised. A second overlap comes from SEVs issued by two cores at once. That case passes if the request vector equals the union of both fan-outs, and if after the acknowledge every mailbox reads back as set.

// File: rtl/evt_ctrl_pkg.sv
`timescale 1ns/1ps
package evt_ctrl_pkg;

    typedef enum logic {
        CORE_AWAKE  = 1'b0,
        CORE_ASLEEP = 1'b1
    } core_state_e;

    // Per-core request bundle presented to a core slice each cycle.
    typedef struct packed {
        logic wfe;        // WFE executed
        logic wfe_ok;     // its condition check passed
        logic sev_own;    // this core issued SEV
        logic sev_remote; // some other core issued SEV
        logic irq_pend;   // unmasked interrupt pending
        logic exc;        // exception entry
        logic ack;        // event interrupt taken
    } core_req_t;

    // Any cause that forces the mailbox to one.
    function automatic logic mbox_force(input core_req_t r);
        return r.sev_own | r.exc | r.ack | (r.wfe & ~r.wfe_ok);
    endfunction

endpackage

// File: rtl/sev_fanout.sv
`timescale 1ns/1ps
module sev_fanout #(
    parameter int N_CORES = 4
) (
    input  logic [N_CORES-1:0] sev,
    output logic [N_CORES-1:0] remote
);
    localparam logic [N_CORES-1:0] BIT0 = N_CORES'(1);

    for (genvar g = 0; g < N_CORES; g++) begin : g_core
        assign remote[g] = |(sev & ~(BIT0 << g));
    end
endmodule

// File: rtl/core_evt_slice.sv
`timescale 1ns/1ps
module core_evt_slice
    import evt_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  core_req_t req,
    output logic      mbox_o,
    output logic      asleep_o,
    output logic      pend_o,
    output logic      wake_o
);
    logic        mbox_q, mbox_d;
    logic        pend_q, pend_d;
    core_state_e st_q, st_d;
    logic        post, sleep_go, wake_now;

    always_comb begin
        post     = req.sev_remote & ~mbox_q;
        sleep_go = req.wfe & req.wfe_ok & ~mbox_q & ~req.irq_pend;
        wake_now = pend_q | post | req.irq_pend;

        if (mbox_force(req))
            mbox_d = 1'b1;
        else if (req.wfe & req.wfe_ok & mbox_q)
            mbox_d = 1'b0;
        else
            mbox_d = mbox_q;

        pend_d = (pend_q & ~req.ack) | post;

        if (wake_now)
            st_d = CORE_AWAKE;
        else if (sleep_go)
            st_d = CORE_ASLEEP;
        else
            st_d = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mbox_q <= 1'b0;
            pend_q <= 1'b0;
            st_q   <= CORE_AWAKE;
        end else begin
            mbox_q <= mbox_d;
            pend_q <= pend_d;
            st_q   <= st_d;
        end
    end

    assign mbox_o   = mbox_q;
    assign pend_o   = pend_q;
    assign asleep_o = (st_q == CORE_ASLEEP);
    assign wake_o   = (st_q == CORE_ASLEEP) & wake_now;
endmodule

// File: rtl/wfe_sev_ctrl.sv
`timescale 1ns/1ps
module wfe_sev_ctrl
    import evt_ctrl_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CORES-1:0] wfe_pulse,
    input  logic [N_CORES-1:0] wfe_cond_ok,
    input  logic [N_CORES-1:0] sev_pulse,
    input  logic [N_CORES-1:0] irq_pending,
    input  logic [N_CORES-1:0] exc_entry,
    input  logic [N_CORES-1:0] evt_ack,
    output logic [N_CORES-1:0] sleeping,
    output logic [N_CORES-1:0] wake,
    output logic [N_CORES-1:0] evt_irq
);
    logic [N_CORES-1:0] sev_remote;
    logic [N_CORES-1:0] mbox_vec;

    sev_fanout #(.N_CORES(N_CORES)) u_fanout (
        .sev    (sev_pulse),
        .remote (sev_remote)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_slice
        core_req_t req;
        always_comb begin
            req.wfe        = wfe_pulse[c];
            req.wfe_ok     = wfe_cond_ok[c];
            req.sev_own    = sev_pulse[c];
            req.sev_remote = sev_remote[c];
            req.irq_pend   = irq_pending[c];
            req.exc        = exc_entry[c];
            req.ack        = evt_ack[c];
        end

        core_evt_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .req      (req),
            .mbox_o   (mbox_vec[c]),
            .asleep_o (sleeping[c]),
            .pend_o   (evt_irq[c]),
            .wake_o   (wake[c])
        );
    end
endmodule

// File: rtl/evt_ctrl_chk.sv
`timescale 1ns/1ps
module evt_ctrl_chk #(
    parameter int N_CORES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_CORES-1:0] wfe_pulse,
    input logic [N_CORES-1:0] wfe_cond_ok,
    input logic [N_CORES-1:0] sev_pulse,
    input logic [N_CORES-1:0] exc_entry,
    input logic [N_CORES-1:0] evt_ack,
    input logic [N_CORES-1:0] sleeping,
    input logic [N_CORES-1:0] wake,
    input logic [N_CORES-1:0] evt_irq,
    input logic [N_CORES-1:0] mbox_vec
);
    logic [N_CORES-1:0] hit_consume;
    logic [N_CORES-1:0] hit_rearm;
    assign hit_consume = wfe_pulse & wfe_cond_ok & mbox_vec;
    assign hit_rearm   = wfe_pulse & ~wfe_cond_ok;

    // R1
    wfe_consume_awake_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_consume != '0) |=> ((sleeping & $past(hit_consume)) == '0));

    // R4
    wfe_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_rearm != '0) |=> (((mbox_vec & $past(hit_rearm)) == $past(hit_rearm))
                               && ((sleeping & $past(hit_rearm)) == '0)));

    // R5
    sev_own_mbox_chk: assert property (@(posedge clk) disable iff (rst)
        (sev_pulse != '0) |=> ((mbox_vec & $past(sev_pulse)) == $past(sev_pulse)));

    // R7
    ack_sets_mbox_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_ack != '0) |=> ((mbox_vec & $past(evt_ack)) == $past(evt_ack)));

    // R8
    exc_sets_mbox_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_entry != '0) |=> ((mbox_vec & $past(exc_entry)) == $past(exc_entry)));

    // R9
    pending_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        ((sleeping & evt_irq) != '0) |=> ((sleeping & $past(sleeping & evt_irq)) == '0));

    // R9
    wake_only_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (wake != '0) |-> ((wake & ~sleeping) == '0));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sleeping == '0 && evt_irq == '0 && mbox_vec == '0));
endmodule

bind wfe_sev_ctrl evt_ctrl_chk #(.N_CORES(N_CORES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wfe_pulse   (wfe_pulse),
    .wfe_cond_ok (wfe_cond_ok),
    .sev_pulse   (sev_pulse),
    .exc_entry   (exc_entry),
    .evt_ack     (evt_ack),
    .sleeping    (sleeping),
    .wake        (wake),
    .evt_irq     (evt_irq),
    .mbox_vec    (mbox_vec)
);

// File: tb/wfe_sev_ctrl_tb.sv
`timescale 1ns/1ps
module wfe_sev_ctrl_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] wfe_pulse   = '0;
    logic [N-1:0] wfe_cond_ok = '0;
    logic [N-1:0] sev_pulse   = '0;
    logic [N-1:0] irq_pending = '0;
    logic [N-1:0] exc_entry   = '0;
    logic [N-1:0] evt_ack     = '0;
    logic [N-1:0] sleeping, wake, evt_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wfe_sev_ctrl #(.N_CORES(N)) u_dut (
        .clk (clk), .rst (rst),
        .wfe_pulse (wfe_pulse), .wfe_cond_ok (wfe_cond_ok),
        .sev_pulse (sev_pulse), .irq_pending (irq_pending),
        .exc_entry (exc_entry), .evt_ack (evt_ack),
        .sleeping (sleeping), .wake (wake), .evt_irq (evt_irq)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // WFE with condition passed: reads the mailbox through the sleep decision.
    // Returns 1 if the core stayed awake. Leaves the mailbox at 0 and the core awake.
    task automatic probe(input int c, output logic mb);
        wfe_pulse[c]   = 1'b1;
        wfe_cond_ok[c] = 1'b1;
        cyc();
        wfe_pulse[c]   = 1'b0;
        wfe_cond_ok[c] = 1'b0;
        mb = ~sleeping[c];
        if (sleeping[c]) begin
            irq_pending[c] = 1'b1;
            cyc();
            irq_pending[c] = 1'b0;
        end
    endtask

    task automatic ack(input logic [N-1:0] m);
        evt_ack = m;
        cyc();
        evt_ack = '0;
    endtask

    task automatic clear_all();
        logic mb;
        for (int c = 0; c < N; c++) probe(c, mb);
    endtask

    task automatic t_reset();
        logic mb;
        chk(sleeping == '0, "R10", 32'(sleeping), 0);
        chk(evt_irq == '0, "R10", 32'(evt_irq), 0);
        chk(wake == '0, "R10", 32'(wake), 0);
        probe(0, mb);
        chk(mb == 1'b0, "R10 mailbox", 32'(mb), 0);
    endtask

    task automatic t_consume();
        logic mb;
        exc_entry[1] = 1'b1;
        cyc();
        exc_entry[1] = 1'b0;
        probe(1, mb);
        chk(mb == 1'b1, "R8/R1 no sleep", 32'(mb), 1);
        probe(1, mb);
        chk(mb == 1'b0, "R1 mailbox cleared", 32'(mb), 0);
    endtask

    task automatic t_irq_skip();
        logic mb;
        wfe_pulse[2] = 1'b1; wfe_cond_ok[2] = 1'b1; irq_pending[2] = 1'b1;
        cyc();
        wfe_pulse[2] = 1'b0; wfe_cond_ok[2] = 1'b0; irq_pending[2] = 1'b0;
        chk(sleeping[2] == 1'b0, "R2 awake", 32'(sleeping), 0);
        probe(2, mb);
        chk(mb == 1'b0, "R2 mailbox kept", 32'(mb), 0);
    endtask

    task automatic t_sleep_sev_wake();
        logic mb;
        wfe_pulse[3] = 1'b1; wfe_cond_ok[3] = 1'b1;
        cyc();
        wfe_pulse[3] = 1'b0; wfe_cond_ok[3] = 1'b0;
        chk(sleeping[3] == 1'b1, "R3 asleep", 32'(sleeping), 8);
        cyc();
        chk(sleeping[3] == 1'b1 && wake == '0, "R3 stays asleep", 32'(sleeping), 8);
        sev_pulse[0] = 1'b1;
        #1;
        chk(wake == 4'b1000, "R9 wake strobe", 32'(wake), 8);
        cyc();
        sev_pulse[0] = 1'b0;
        chk(sleeping == '0, "R9 awake", 32'(sleeping), 0);
        chk(evt_irq == 4'b1110, "R6 post to others", 32'(evt_irq), 32'he);
        ack(4'b1110);
        chk(evt_irq == '0, "R7 request cleared", 32'(evt_irq), 0);
        for (int c = 1; c < N; c++) begin
            probe(c, mb);
            chk(mb == 1'b1, "R7 mailbox set", 32'(mb), 1);
        end
        probe(0, mb);
        chk(mb == 1'b1, "R5 own mailbox", 32'(mb), 1);
    endtask

    task automatic t_irq_wake();
        wfe_pulse[3] = 1'b1; wfe_cond_ok[3] = 1'b1;
        cyc();
        wfe_pulse[3] = 1'b0; wfe_cond_ok[3] = 1'b0;
        chk(sleeping[3] == 1'b1, "R3 asleep", 32'(sleeping), 8);
        irq_pending[3] = 1'b1;
        #1;
        chk(wake[3] == 1'b1, "R9 irq wake strobe", 32'(wake), 8);
        cyc();
        irq_pending[3] = 1'b0;
        chk(sleeping[3] == 1'b0, "R9 irq wakes", 32'(sleeping), 0);
    endtask

    task automatic t_cond_fail();
        logic mb;
        wfe_pulse[2] = 1'b1; wfe_cond_ok[2] = 1'b0;
        cyc();
        wfe_pulse[2] = 1'b0;
        chk(sleeping[2] == 1'b0, "R4 awake", 32'(sleeping), 0);
        probe(2, mb);
        chk(mb == 1'b1, "R4 mailbox rearmed", 32'(mb), 1);
    endtask

    task automatic t_sev_filter();
        exc_entry[1] = 1'b1;
        cyc();
        exc_entry[1] = 1'b0;
        sev_pulse[0] = 1'b1;
        cyc();
        sev_pulse[0] = 1'b0;
        chk(evt_irq == 4'b1100, "R6 skip set mailbox", 32'(evt_irq), 32'hc);
        ack(4'b1100);
        clear_all();
    endtask

    task automatic t_dual_sev();
        logic mb;
        sev_pulse = 4'b0101;
        cyc();
        sev_pulse = '0;
        chk(evt_irq == 4'b1111, "R11 union", 32'(evt_irq), 32'hf);
        ack(4'b1111);
        for (int c = 0; c < N; c++) begin
            probe(c, mb);
            chk(mb == 1'b1, "R11 mailbox", 32'(mb), 1);
        end
    endtask

    task automatic t_wake_vs_sleep();
        wfe_pulse[1] = 1'b1; wfe_cond_ok[1] = 1'b1;
        sev_pulse[0] = 1'b1;
        cyc();
        wfe_pulse[1] = 1'b0; wfe_cond_ok[1] = 1'b0;
        sev_pulse[0] = 1'b0;
        chk(sleeping[1] == 1'b0, "R12 wake wins", 32'(sleeping), 0);
        chk(evt_irq[1] == 1'b1, "R12 request raised", 32'(evt_irq), 32'he);
        ack(4'b1110);
        clear_all();
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_consume();
        t_irq_skip();
        t_sleep_sev_wake();
        t_irq_wake();
        t_cond_fail();
        t_sev_filter();
        t_dual_sev();
        t_wake_vs_sleep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule